// File: doc/BRIEF.md
# Banked GPIO Controller with Atomic Set/Clear Attribute Registers

This block controls 32 general-purpose pins arranged as two banks of 16. Each pin has eight attributes: output value, output enable, open-drain, output invert, pull-up, pull-down, input enable and input invert. Every attribute is held in its own 16-bit register per bank. A host changes an attribute through a 32-bit write in which the upper half-word clears bits and the lower half-word sets bits. Software can therefore change one pin without a read-modify-write sequence, and it cannot disturb a neighbouring pin that another agent is changing at the same time.

Host writes take effect at the clock edge on which `wr_en` is sampled. Pad-side outputs (`pad_out`, `pad_oe`, `pad_pu`, `pad_pd`) follow combinationally from the stored attributes. Pad inputs pass through a two-flop synchronizer. The result is inverted where input invert is set and forced to zero where input enable is clear, and it is returned through a read-back register. Reads are registered: `rdata` holds the addressed value from the edge that samples `rd_en` and keeps it until the next read.

The block has no sequencing of its own. Every register is a plain clocked store, so there are no named states or transitions.

Top module: `gpio_banked_ctrl`

## Requirements
- R1: After reset every attribute of every pin is 0, so `pad_out`, `pad_oe`, `pad_pu`, `pad_pd` and `rdata` are all 0.
- R2: A write with bit n (n < 16) of `wdata` at 1 sets the addressed attribute for local pin n of the addressed bank. The change is visible from the next clock edge.
- R3: A write with bit n+16 at 1 clears that attribute for local pin n. A bit position whose set and clear bits are both 0 keeps its previous value.
- R4: If one write has both bit n and bit n+16 at 1, the attribute for pin n ends up cleared.
- R5: Address bit 7 selects the bank: 0 selects pins 0..15 and 1 selects pins 16..31, and a pin's local bit is (pin & 0xF). Within a bank the byte offsets are: 0x00 output value, 0x04 output enable, 0x08 open-drain, 0x0C output invert, 0x18 pull-up, 0x1C pull-down, 0x20 input enable, 0x24 input invert, 0x30 read-back.
- R6: A read of an attribute register returns its 16 bits in `rdata[15:0]` and zeros in `rdata[31:16]`. The value appears on `rdata` after the clock edge that samples `rd_en`.
- R7: With open-drain clear, `pad_out` for a pin is output value XOR output invert, and `pad_oe` equals output enable.
- R8: With open-drain set, `pad_out` is 0. `pad_oe` is asserted only when output enable is 1 and (output value XOR output invert) is 0.
- R9: `pad_pu` and `pad_pd` equal the pull-up and pull-down attributes of each pin.
- R10: A read of read-back returns, for each local pin, the pad input after two synchronizer flops XOR input invert, or 0 where input enable is clear. A change on `pad_in` first shows in a read whose `rd_en` is sampled on the third edge after the change.
- R11: Offsets not listed in R5 read as 0, and writes to them or to read-back change no attribute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 8 | Byte address: bit 7 bank, bits 6:0 offset |
| wdata | input | 32 | Write data: [31:16] clear mask, [15:0] set mask |
| rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Pad input levels, asynchronous |
| pad_out | output | 32 | Pad output levels |
| pad_oe | output | 32 | Pad output enables |
| pad_pu | output | 32 | Pull-up enables |
| pad_pd | output | 32 | Pull-down enables |

## Verification
A set and a clear can land on the same pin in one write, and a set on one pin can coincide with a clear on another pin of the same register. The bench provokes both with single writes whose two half-words overlap on some bits and not on others. It judges the result by reading the register back: overlapping bits must be 0, bits that were only set must be 1, and untouched bits must keep their old values. A second collision occurs between the synchronizer and the read path. The bench changes `pad_in` in the same cycle as a read-back request and checks that the old level is returned before the new one.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int ATTR_COUNT = 8;
    localparam int OFFSET_W   = 7;

    typedef enum logic [2:0] {
        A_OUTVAL = 3'd0,
        A_OUTEN  = 3'd1,
        A_OPENDR = 3'd2,
        A_OUTINV = 3'd3,
        A_PULLUP = 3'd4,
        A_PULLDN = 3'd5,
        A_INEN   = 3'd6,
        A_ININV  = 3'd7
    } attr_e;

    typedef struct packed {
        logic  hit;
        attr_e idx;
    } attr_sel_t;

    localparam logic [OFFSET_W-1:0] RB_OFFSET = 7'h30;

    function automatic attr_sel_t decode_offset(input logic [OFFSET_W-1:0] off);
        attr_sel_t s;
        s.hit = 1'b1;
        s.idx = A_OUTVAL;
        case (off)
            7'h00:   s.idx = A_OUTVAL;
            7'h04:   s.idx = A_OUTEN;
            7'h08:   s.idx = A_OPENDR;
            7'h0C:   s.idx = A_OUTINV;
            7'h18:   s.idx = A_PULLUP;
            7'h1C:   s.idx = A_PULLDN;
            7'h20:   s.idx = A_INEN;
            7'h24:   s.idx = A_ININV;
            default: s.hit = 1'b0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gpio_attr_reg.sv
module gpio_attr_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] set_bits,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr) begin
            q <= (q | set_bits) & ~clr_bits;
        end
    end

    // R2: bits set without a matching clear read 1 afterwards
    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> ((q & $past(set_bits & ~clr_bits)) == $past(set_bits & ~clr_bits)));

    // R3 / R4: any bit named in the clear mask is 0 afterwards
    p_clear_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> ((q & $past(clr_bits)) == '0));

    // R3: bits named in neither mask keep their value
    p_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (((q ^ $past(q)) & ~$past(set_bits | clr_bits)) == '0));

    // R11: no write strobe, no change
    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(q));

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] out_val,
    input  logic [W-1:0] out_en,
    input  logic [W-1:0] open_dr,
    input  logic [W-1:0] out_inv,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe
);

    logic [W-1:0] level;

    always_comb begin
        level   = out_val ^ out_inv;
        pad_out = level & ~open_dr;
        pad_oe  = out_en & ~(open_dr & level);
    end

    // R7: no pad is driven without its output enable
    p_oe_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~out_en) == '0);

    // R8: an open-drain pad never drives high
    p_od_no_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & open_dr) == '0);

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_in,
    input  logic [W-1:0] in_en,
    input  logic [W-1:0] in_inv,
    output logic [W-1:0] rb
);

    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= pad_in;
            stage2 <= stage1;
        end
    end

    assign rb = in_en & (stage2 ^ in_inv);

    // R10: second stage follows the first with one cycle of delay
    p_two_flop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (stage2 == $past(stage1)));

    // R10: disabled inputs read as zero
    p_in_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rb & ~in_en) == '0);

endmodule

// File: rtl/gpio_banked_ctrl.sv
module gpio_banked_ctrl
    import gpio_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int BANK_PINS = 16,
    parameter int ADDR_W    = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic                           rd_en,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [2*BANK_PINS-1:0]         wdata,
    output logic [2*BANK_PINS-1:0]         rdata,
    input  logic [NUM_BANKS*BANK_PINS-1:0] pad_in,
    output logic [NUM_BANKS*BANK_PINS-1:0] pad_out,
    output logic [NUM_BANKS*BANK_PINS-1:0] pad_oe,
    output logic [NUM_BANKS*BANK_PINS-1:0] pad_pu,
    output logic [NUM_BANKS*BANK_PINS-1:0] pad_pd
);

    localparam int DATA_W = 2 * BANK_PINS;
    localparam int BANK_W = ADDR_W - OFFSET_W;

    logic [BANK_W-1:0]   bank_f;
    logic [OFFSET_W-1:0] offset;
    attr_sel_t           sel;
    logic [BANK_PINS-1:0] set_m;
    logic [BANK_PINS-1:0] clr_m;

    logic [BANK_PINS-1:0] attr_q [NUM_BANKS][ATTR_COUNT];
    logic [BANK_PINS-1:0] rb_q   [NUM_BANKS];
    logic [DATA_W-1:0]    rd_next;

    assign bank_f = addr[ADDR_W-1:OFFSET_W];
    assign offset = addr[OFFSET_W-1:0];
    assign sel    = decode_offset(offset);
    assign set_m  = wdata[BANK_PINS-1:0];
    assign clr_m  = wdata[DATA_W-1:BANK_PINS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic bank_hit;
        assign bank_hit = (bank_f == BANK_W'(b));

        for (genvar a = 0; a < ATTR_COUNT; a++) begin : g_attr
            logic wr_this;
            assign wr_this = wr_en && bank_hit && sel.hit && (sel.idx == attr_e'(a));
            gpio_attr_reg #(.W(BANK_PINS)) u_reg (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr       (wr_this),
                .set_bits (set_m),
                .clr_bits (clr_m),
                .q        (attr_q[b][a])
            );
        end

        gpio_pad_drive #(.W(BANK_PINS)) u_drive (
            .clk     (clk),
            .rst_n   (rst_n),
            .out_val (attr_q[b][A_OUTVAL]),
            .out_en  (attr_q[b][A_OUTEN]),
            .open_dr (attr_q[b][A_OPENDR]),
            .out_inv (attr_q[b][A_OUTINV]),
            .pad_out (pad_out[b*BANK_PINS +: BANK_PINS]),
            .pad_oe  (pad_oe[b*BANK_PINS +: BANK_PINS])
        );

        gpio_in_sync #(.W(BANK_PINS)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .pad_in (pad_in[b*BANK_PINS +: BANK_PINS]),
            .in_en  (attr_q[b][A_INEN]),
            .in_inv (attr_q[b][A_ININV]),
            .rb     (rb_q[b])
        );

        assign pad_pu[b*BANK_PINS +: BANK_PINS] = attr_q[b][A_PULLUP];
        assign pad_pd[b*BANK_PINS +: BANK_PINS] = attr_q[b][A_PULLDN];
    end

    always_comb begin
        rd_next = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_f == BANK_W'(b)) begin
                if (sel.hit) begin
                    rd_next = {{BANK_PINS{1'b0}}, attr_q[b][sel.idx]};
                end else if (offset == RB_OFFSET) begin
                    rd_next = {{BANK_PINS{1'b0}}, rb_q[b]};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_next;
        end
    end

    // R6: reads never return bits in the upper half-word
    p_rd_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (rdata[DATA_W-1:BANK_PINS] == '0));

    // R11: an unmapped offset reads as zero
    p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !sel.hit && (offset != RB_OFFSET)) |=> (rdata == '0));

    // R6: rdata holds between reads
    p_rd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

endmodule

// File: tb/gpio_banked_ctrl_bench.sv
module gpio_banked_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe, pad_pu, pad_pd;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    gpio_banked_ctrl u_gpio_banked_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd)
    );

    localparam logic [7:0] OFFS [8] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h18, 8'h1C, 8'h20, 8'h24};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic read_reg(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic clear_all();
        for (int bk = 0; bk < 2; bk++)
            for (int i = 0; i < 8; i++)
                write_reg(OFFS[i] | 8'(bk * 8'h80), 32'hFFFF_0000);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 pad_out", pad_out, 32'h0);
        check("R1 pad_oe", pad_oe, 32'h0);
        check("R1 pad_pu|pad_pd", pad_pu | pad_pd, 32'h0);
        read_reg(8'h04, d);
        check("R1 outen read", d, 32'h0);
    endtask

    task automatic t_set_clear();
        logic [31:0] d;
        clear_all();
        write_reg(8'h04, 32'h0000_00F0);
        read_reg(8'h04, d);
        check("R2 set bits", d, 32'h0000_00F0);
        write_reg(8'h04, 32'h0010_0000);
        read_reg(8'h04, d);
        check("R3 clear bit 4", d, 32'h0000_00E0);
        write_reg(8'h04, 32'h0000_0000);
        read_reg(8'h04, d);
        check("R3 zero write keeps", d, 32'h0000_00E0);
    endtask

    task automatic t_collide();
        logic [31:0] d;
        clear_all();
        write_reg(8'h00, 32'h0000_0003);
        write_reg(8'h00, 32'h0001_0005);
        read_reg(8'h00, d);
        check("R4 clear wins, others kept", d, 32'h0000_0006);
    endtask

    task automatic t_banks();
        logic [31:0] d;
        clear_all();
        for (int i = 0; i < 8; i++)
            write_reg(8'h80 | OFFS[i], 32'((i + 1) * 32'h0101));
        for (int i = 0; i < 8; i++) begin
            read_reg(8'h80 | OFFS[i], d);
            check("R5 high bank offset map", d, 32'((i + 1) * 32'h0101));
        end
        read_reg(8'h00, d);
        check("R5 low bank untouched", d, 32'h0);
        check("R6 upper half zero", {16'h0, d[31:16]}, 32'h0);
    endtask

    task automatic t_push_pull();
        clear_all();
        write_reg(8'h04, 32'h0000_000F);
        write_reg(8'h00, 32'h0000_0005);
        write_reg(8'h0C, 32'h0000_0003);
        check("R7 pad_out", pad_out, 32'h0000_0006);
        check("R7 pad_oe", pad_oe, 32'h0000_000F);
    endtask

    task automatic t_open_drain();
        clear_all();
        write_reg(8'h84, 32'h0000_000F);
        write_reg(8'h80, 32'h0000_0005);
        write_reg(8'h88, 32'h0000_000F);
        check("R8 od pad_out low", pad_out, 32'h0);
        check("R8 od pad_oe", pad_oe, 32'h000A_0000);
        write_reg(8'h8C, 32'h0000_0001);
        check("R8 od with invert", pad_oe, 32'h000B_0000);
    endtask

    task automatic t_pulls();
        clear_all();
        write_reg(8'h98, 32'h0000_00FF);
        write_reg(8'h9C, 32'h0000_FF00);
        check("R9 pad_pu", pad_pu, 32'h00FF_0000);
        check("R9 pad_pd", pad_pd, 32'hFF00_0000);
    endtask

    task automatic t_readback();
        logic [31:0] d;
        clear_all();
        pad_in = 32'h0;
        write_reg(8'h20, 32'h0000_FFFF);
        write_reg(8'h24, 32'h0000_00FF);
        write_reg(8'hA0, 32'h0000_0F0F);
        repeat (3) @(negedge clk);
        @(negedge clk);
        pad_in = 32'hA5A5_3C3C; rd_en = 1'b1; addr = 8'h30;
        @(negedge clk);
        rd_en = 1'b0;
        check("R10 old level before sync", rdata, 32'h0000_00FF);
        repeat (3) @(negedge clk);
        read_reg(8'h30, d);
        check("R10 low readback", d, 32'h0000_3CC3);
        read_reg(8'hB0, d);
        check("R10 high readback gated", d, 32'h0000_0505);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        clear_all();
        write_reg(8'h10, 32'h0000_FFFF);
        write_reg(8'h14, 32'h0000_FFFF);
        write_reg(8'h2C, 32'h0000_FFFF);
        write_reg(8'h30, 32'h0000_FFFF);
        write_reg(8'hB4, 32'h0000_FFFF);
        check("R11 no pad change", pad_out | pad_oe | pad_pu | pad_pd, 32'h0);
        read_reg(8'h10, d);
        check("R11 unmapped reads zero", d, 32'h0);
        for (int i = 0; i < 8; i++) begin
            read_reg(OFFS[i], d);
            check("R11 attributes untouched", d, 32'h0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_set_clear();
        t_collide();
        t_banks();
        t_push_pull();
        t_open_drain();
        t_pulls();
        t_readback();
        t_unmapped();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule